// File: doc/BRIEF.md
# Memory Bus Error Response Controller

This block sits next to an on-chip memory and its APB register port. It converts four error events into bus error responses. The events are an uncorrectable ECC error, an access to a powered-down bank, a security poison flag from a protection unit, and an APB access to an offset with no register behind it. A control register holds one enable per source. When a source's enable is clear, the access still completes with an OKAY response. The source's interrupt status bit is set in either case.

The memory side sees a two-bit response code for each completing access, using the AXI encoding. The APB side gets an error flag on accesses to unimplemented offsets. Software reads and writes three registers over APB. Control sits at offset 0x0, interrupt status at 0x4 (write 1 to clear) and interrupt mask at 0x8. A single interrupt line is the OR of the status bits whose mask bits are set.

Top module: `mem_err_resp_ctrl`

## Requirements
- R1: After reset, control reads 0x0000000F, interrupt status reads 0, interrupt mask reads 0, and `irq_o` is low.
- R2: Bits 31:4 of control, status and mask read as zero, and writes to those bits have no effect.
- R3: A completing access with `ecc_ue_i` high returns SLVERR (2'b10) when control bit 3 is 1, and OKAY (2'b00) when it is 0.
- R4: A completing access with `bank_off_i` high returns DECERR (2'b11) when control bit 2 is 1, and OKAY when it is 0.
- R5: A completing access with `poison_i` high returns DECERR when control bit 1 is 1, and OKAY when it is 0.
- R6: When a DECERR source and a SLVERR source both hit the same access, DECERR wins. `mem_resp_o` is OKAY whenever `mem_valid_i` is low.
- R7: An APB access to an offset other than 0x0, 0x4 or 0x8 raises `pslverr_o` in its access cycle when control bit 0 is 1, and leaves it low when bit 0 is 0. Such a read returns 0, and such a write changes no register.
- R8: On the clock after an event, its status bit is set whatever its enable says, and it stays set until cleared. The bit mapping is: bit 3 ECC, bit 2 powered-down bank, bit 1 poison, bit 0 unimplemented APB offset.
- R9: Writing 1s to offset 0x4 clears the matching status bits. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: `irq_o` equals the OR of (status AND mask), where the mask is bits 3:0 at offset 0x8.
- R11: `pready_o` is high only in the APB access phase (`psel_i` and `penable_i` both high), and `pslverr_o` is never high outside that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, zero outside a read access |
| pready_o | output | 1 | APB ready, high in the access phase |
| pslverr_o | output | 1 | APB error flag for unimplemented offsets |
| mem_valid_i | input | 1 | A memory access completes this cycle |
| ecc_ue_i | input | 1 | Uncorrectable ECC error on the access |
| bank_off_i | input | 1 | Access targets a powered-down bank |
| poison_i | input | 1 | Security poison on the access |
| mem_resp_o | output | 2 | Response code: 00 OKAY, 10 SLVERR, 11 DECERR |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Each memory-side source is driven alone, with its enable set and then cleared. This separates the enable gating of the response from the interrupt status path, which must still record the event. ECC and bank-off errors are then driven on the same access to expose the DECERR-over-SLVERR priority. An ECC flag is also driven with `mem_valid_i` low, which shows that events are qualified by a completing access. On the APB side, legal and illegal offsets are each tried with the error enable on and off, and a status clear is issued in the same cycle as a fresh event to settle which one wins.

// File: rtl/mer_pkg.sv
package mer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 4;

  localparam int unsigned SRC_APB  = 0;
  localparam int unsigned SRC_PSN  = 1;
  localparam int unsigned SRC_BANK = 2;
  localparam int unsigned SRC_ECC  = 3;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  localparam logic [NSRC-1:0] CTRL_RST = '1;
endpackage

// File: rtl/mer_resp.sv
module mer_resp
  import mer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mem_valid_i,
  input  logic            ecc_ue_i,
  input  logic            bank_off_i,
  input  logic            poison_i,
  input  logic [NSRC-1:0] en_i,
  output logic [1:0]      resp_o
);
  logic dec_hit, slv_hit;

  assign dec_hit = mem_valid_i & ((bank_off_i & en_i[SRC_BANK]) | (poison_i & en_i[SRC_PSN]));
  assign slv_hit = mem_valid_i & ecc_ue_i & en_i[SRC_ECC];

  always_comb begin
    if (dec_hit)      resp_o = RESP_DECERR;
    else if (slv_hit) resp_o = RESP_SLVERR;
    else              resp_o = RESP_OKAY;
  end

  assert_idle_okay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_valid_i |-> resp_o == RESP_OKAY);
  assert_legal_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o != 2'b01);
  assert_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && bank_off_i && en_i[SRC_BANK] && ecc_ue_i) |-> resp_o == RESP_DECERR);
endmodule

// File: rtl/mer_irq.sv
module mer_irq
  import mer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic [NSRC-1:0] stat_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[g] <= 1'b0;
      else if (evt_i[g]) stat_q[g] <= 1'b1;   // set beats clear
      else if (clr_i[g]) stat_q[g] <= 1'b0;
    end

    assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> stat_q[g]);
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[g] && !clr_i[g]) |=> stat_q[g]);
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/mer_regs.sv
module mer_regs
  import mer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [NSRC-1:0]   stat_i,
  output logic [NSRC-1:0]   ctrl_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   clr_o,
  output logic              bad_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8);

  logic access, wr, sel_ctrl, sel_stat, sel_mask;
  logic [NSRC-1:0] ctrl_q, mask_q, rd_bits;

  assign access   = psel_i & penable_i;
  assign wr       = access & pwrite_i;
  assign sel_ctrl = paddr_i == OFS_CTRL;
  assign sel_stat = paddr_i == OFS_STAT;
  assign sel_mask = paddr_i == OFS_MASK;
  assign bad_o    = access & ~(sel_ctrl | sel_stat | sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      mask_q <= '0;
    end else if (wr) begin
      if (sel_ctrl) ctrl_q <= pwdata_i[NSRC-1:0];
      if (sel_mask) mask_q <= pwdata_i[NSRC-1:0];
    end
  end

  assign clr_o = (wr && sel_stat) ? pwdata_i[NSRC-1:0] : '0;

  always_comb begin
    rd_bits = '0;
    if (access && !pwrite_i) begin
      if (sel_ctrl)      rd_bits = ctrl_q;
      else if (sel_stat) rd_bits = stat_i;
      else if (sel_mask) rd_bits = mask_q;
    end
  end

  assign prdata_o  = {{(DATA_W-NSRC){1'b0}}, rd_bits};
  assign pready_o  = access;
  assign pslverr_o = bad_o & ctrl_q[SRC_APB];
  assign ctrl_o    = ctrl_q;
  assign mask_o    = mask_q;

  assert_err_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (psel_i && penable_i));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prdata_o[DATA_W-1:NSRC] == '0);
  assert_bad_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> ($stable(ctrl_q) && $stable(mask_q)));
endmodule

// File: rtl/mem_err_resp_ctrl.sv
module mem_err_resp_ctrl
  import mer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              mem_valid_i,
  input  logic              ecc_ue_i,
  input  logic              bank_off_i,
  input  logic              poison_i,
  output logic [1:0]        mem_resp_o,
  output logic              irq_o
);
  logic [NSRC-1:0] ctrl, mask, clr, stat, evt;
  logic            bad;

  mer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o, .pready_o, .pslverr_o,
    .stat_i(stat), .ctrl_o(ctrl), .mask_o(mask), .clr_o(clr), .bad_o(bad)
  );

  mer_resp u_resp (
    .clk_i, .rst_ni, .mem_valid_i, .ecc_ue_i, .bank_off_i, .poison_i,
    .en_i(ctrl), .resp_o(mem_resp_o)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_ECC]  = mem_valid_i & ecc_ue_i;
    evt[SRC_BANK] = mem_valid_i & bank_off_i;
    evt[SRC_PSN]  = mem_valid_i & poison_i;
    evt[SRC_APB]  = bad;
  end

  mer_irq u_irq (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(clr), .mask_i(mask),
    .stat_o(stat), .irq_o
  );
endmodule

// File: tb/mem_err_resp_ctrl_test.sv
module mem_err_resp_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic mvalid = 0, ue = 0, boff = 0, psn = 0;
  logic [1:0] mresp;
  logic irq;

  int total = 0, bad = 0, cyc = 0;
  logic [3:0] m_ctrl = 4'hF, m_stat = 0, m_mask = 0;
  logic [31:0] rd_cap;
  logic [1:0] resp_cap;
  logic err_cap;

  always #10 clk = ~clk;

  mem_err_resp_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .mem_valid_i(mvalid), .ecc_ue_i(ue), .bank_off_i(boff),
    .poison_i(psn), .mem_resp_o(mresp), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic is_bad_addr(input logic [11:0] a);
    return !(a == 12'h0 || a == 12'h4 || a == 12'h8);
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 4'hF; m_stat <= 0; m_mask <= 0;
    end else begin
      logic [3:0] set, clr;
      logic acc;
      acc = psel && penable;
      set = {mvalid && ue, mvalid && boff, mvalid && psn, acc && is_bad_addr(paddr)};
      clr = (acc && pwrite && paddr == 12'h4) ? pwdata[3:0] : 4'h0;
      m_stat <= (m_stat & ~clr) | set;
      if (acc && pwrite && paddr == 12'h0) m_ctrl <= pwdata[3:0];
      if (acc && pwrite && paddr == 12'h8) m_mask <= pwdata[3:0];
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic acc;
      logic [1:0] er;
      logic [31:0] ed;
      acc = psel && penable;
      er = 2'b00;
      if (mvalid && ((boff && m_ctrl[2]) || (psn && m_ctrl[1]))) er = 2'b11;
      else if (mvalid && ue && m_ctrl[3]) er = 2'b10;
      ed = 0;
      if (acc && !pwrite) begin
        if (paddr == 12'h0) ed = {28'h0, m_ctrl};
        else if (paddr == 12'h4) ed = {28'h0, m_stat};
        else if (paddr == 12'h8) ed = {28'h0, m_mask};
      end
      chk("R6", "mem_resp", {30'h0, mresp}, {30'h0, er});
      chk("R9", "prdata", prdata, ed);
      chk("R7", "pslverr", {31'h0, pslverr}, {31'h0, acc && is_bad_addr(paddr) && m_ctrl[0]});
      chk("R11", "pready", {31'h0, pready}, {31'h0, acc});
      chk("R10", "irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
    end
  end

  task automatic apb(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #5;
    psel = 1; pwrite = w; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    chk("R11", "pready setup", {31'h0, pready}, 32'h0);
    @(posedge clk); #5;
    penable = 1;
    @(negedge clk);
    rd_cap = prdata; err_cap = pslverr;
    @(posedge clk); #5;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic mem(input logic v, input logic u, input logic b, input logic p);
    @(posedge clk); #5;
    mvalid = v; ue = u; boff = b; psn = p;
    @(negedge clk);
    resp_cap = mresp;
    @(posedge clk); #5;
    mvalid = 0; ue = 0; boff = 0; psn = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    apb(0, 12'h0, 0); chk("R1", "ctrl reset", rd_cap, 32'hF);
    apb(0, 12'h4, 0); chk("R1", "stat reset", rd_cap, 32'h0);
    apb(0, 12'h8, 0); chk("R1", "mask reset", rd_cap, 32'h0);

    apb(1, 12'h0, 32'hFFFF_FFF0);
    apb(0, 12'h0, 0); chk("R2", "ctrl reserved", rd_cap, 32'h0);
    apb(1, 12'h0, 32'hF);

    mem(1, 1, 0, 0); chk("R3", "ecc enabled", {30'h0, resp_cap}, 32'h2);
    apb(1, 12'h0, 32'h7);
    mem(1, 1, 0, 0); chk("R3", "ecc disabled", {30'h0, resp_cap}, 32'h0);
    mem(1, 0, 1, 0); chk("R4", "bank enabled", {30'h0, resp_cap}, 32'h3);
    apb(1, 12'h0, 32'hB);
    mem(1, 0, 1, 0); chk("R4", "bank disabled", {30'h0, resp_cap}, 32'h0);
    apb(1, 12'h0, 32'hF);
    mem(1, 0, 0, 1); chk("R5", "poison enabled", {30'h0, resp_cap}, 32'h3);
    apb(1, 12'h0, 32'hD);
    mem(1, 0, 0, 1); chk("R5", "poison disabled", {30'h0, resp_cap}, 32'h0);
    apb(1, 12'h0, 32'hF);
    mem(1, 1, 1, 0); chk("R6", "decerr over slverr", {30'h0, resp_cap}, 32'h3);
    mem(0, 1, 1, 1); chk("R6", "no valid", {30'h0, resp_cap}, 32'h0);

    apb(0, 12'h4, 0); chk("R8", "status after mem events", rd_cap, 32'hE);
    apb(0, 12'hC, 0);
    chk("R7", "bad read pslverr", {31'h0, err_cap}, 32'h1);
    chk("R7", "bad read data", rd_cap, 32'h0);
    apb(0, 12'h4, 0); chk("R8", "status apb bit", rd_cap, 32'hF);
    apb(1, 12'h0, 32'hE);
    apb(1, 12'h10, 32'hFFFF_FFFF);
    chk("R7", "bad write disabled", {31'h0, err_cap}, 32'h0);
    apb(0, 12'h0, 0); chk("R7", "ctrl untouched", rd_cap, 32'hE);
    apb(0, 12'h8, 0); chk("R7", "mask untouched", rd_cap, 32'h0);

    apb(1, 12'h4, 32'h3);
    apb(0, 12'h4, 0); chk("R9", "w1c", rd_cap, 32'hC);
    apb(1, 12'h8, 32'h4);
    @(negedge clk); chk("R10", "irq masked in", {31'h0, irq}, 32'h1);
    apb(1, 12'h8, 32'h1);
    @(negedge clk); chk("R10", "irq masked out", {31'h0, irq}, 32'h0);

    // clear and set of bit 3 in the same cycle
    @(posedge clk); #5;
    psel = 1; pwrite = 1; paddr = 12'h4; pwdata = 32'h8;
    @(posedge clk); #5;
    penable = 1; mvalid = 1; ue = 1;
    @(posedge clk); #5;
    psel = 0; penable = 0; pwrite = 0; mvalid = 0; ue = 0;
    apb(0, 12'h4, 0); chk("R9", "set beats clear", rd_cap, 32'hC);

    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule